// File: doc/BRIEF.md
# Flash Write Status Generator

This block sits in the read path of a parallel NOR flash model. It stands in for the array while an internal program or erase runs. A start pulse arrives from the command decoder with an operation kind and, for a program, the byte being written. The block then holds a busy state for a programmable number of clock cycles. While busy, every read returns an end-of-write status byte instead of array contents.

The status byte follows a fixed layout. Bit 7 is a polarity flag: it carries the inverse of the written byte's bit 7 for a program and reads 0 for either erase. Bit 6 alternates on each read and starts at 1. All other bits are 0. Once the timer expires, reads return the array byte supplied from outside. In identification mode, two fixed addresses return a manufacturer code and a device code. Command decoding and array storage are handled outside this block. The busy output goes back to the decoder.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, busy_o is 0 and rdata_o is 00h.
- R2: A start_i pulse taken while idle, with op_i of 00 (program), 01 (sector erase) or 10 (chip erase), raises busy_o at that clock edge. busy_o then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles respectively. A start with op_i = 11 is ignored, and busy_o stays 0.
- R3: A start_i pulse while busy_o is high is ignored. It does not extend the busy time, and it does not change the operation kind or the latched write byte.
- R4: A read taken while busy during a program returns bit 7 equal to the inverse of wdata_i[7] as latched at start. Bits 5..0 are 0.
- R5: A read taken while busy during a sector or chip erase returns bit 7 = 0. Bits 5..0 are 0.
- R6: Bit 6 of busy reads alternates on each read. The first busy read after any accepted start returns 1, whatever state the previous operation left.
- R7: A read taken while idle, outside the identification window, returns array_data_i. After an erase completes, this is the array's erased value.
- R8: With id_mode_i high and the block idle, a read at address 0 returns MFR_CODE (default BFh), a read at address 1 returns DEV_CODE, and any other address returns array_data_i. While busy, status takes priority over identification mode.
- R9: rdata_o is loaded at the clock edge that samples rd_i high. It keeps its value in every cycle where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts an internal write |
| op_i | input | 2 | Operation kind: 00 program, 01 sector erase, 10 chip erase, 11 none |
| wdata_i | input | 8 | Byte being programmed, sampled with start_i |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Read address, used for the identification window |
| id_mode_i | input | 1 | Identification mode active |
| array_data_i | input | 8 | Array byte at rd_addr_i |
| busy_o | output | 1 | Internal write in progress |
| rdata_o | output | 8 | Registered read data |

## Verification
busy_o rises at the edge that samples start_i. It is high for exactly the configured number of sampled edges. The bench drives on falling edges and counts busy cycles from the falling edge right after the start. Each read result appears at the rising edge that samples rd_i, so the bench checks rdata_o at the next falling edge. Back-to-back reads therefore land on consecutive cycles, and N reads after a start fall exactly inside an N-cycle busy window, with the read after them idle. Every operation kind is swept against six write bytes. The expected status byte is computed from the operation kind and the read index.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_NONE = 2'b11
  } op_e;
endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
  parameter int PROG_CYC = 5,
  parameter int SECT_CYC = 8,
  parameter int CHIP_CYC = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  output logic       accept_o,
  output logic       busy_o
);
  import fws_pkg::*;
  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SECT_LD = CNT_W'(SECT_CYC - 1);
  localparam logic [CNT_W-1:0] CHIP_LD = CNT_W'(CHIP_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  assign accept_o = start_i & ~busy_q & (op_i != OP_NONE);
  assign busy_o   = busy_q;

  always_comb begin
    case (op_i)
      OP_PROG: load = PROG_LD;
      OP_SECT: load = SECT_LD;
      default: load = CHIP_LD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= load;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fws_status.sv
module fws_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_busy_i,
  output logic [7:0] status_o
);
  import fws_pkg::*;
  logic erase_q;
  logic inv7_q;
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_q <= 1'b0;
      inv7_q  <= 1'b0;
      tgl_q   <= 1'b1;
    end else if (accept_i) begin
      erase_q <= (op_i != OP_PROG);
      inv7_q  <= ~wdata_i[7];
      tgl_q   <= 1'b1;
    end else if (rd_busy_i) begin
      tgl_q <= ~tgl_q;
    end
  end

  assign status_o = {(erase_q ? 1'b0 : inv7_q), tgl_q, 6'b0};
endmodule

// File: rtl/fws_rdmux.sv
module fws_rdmux #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'hC3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_mode_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        idle_o
);
  localparam logic [ADDR_W-1:0] ID_MFR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_DEV = ADDR_W'(1);

  always_comb begin
    idle_o = array_data_i;
    if (id_mode_i) begin
      if (addr_i == ID_MFR)      idle_o = MFR_CODE;
      else if (addr_i == ID_DEV) idle_o = DEV_CODE;
    end
  end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
  parameter int         ADDR_W   = 8,
  parameter int         PROG_CYC = 5,
  parameter int         SECT_CYC = 8,
  parameter int         CHIP_CYC = 13,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'hC3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              id_mode_i,
  input  logic [7:0]        array_data_i,
  output logic              busy_o,
  output logic [7:0]        rdata_o
);
  logic       accept;
  logic       busy;
  logic [7:0] status;
  logic [7:0] idle_data;
  logic [7:0] rdata_q;

  fws_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) i_timer (
    .clk_i, .rst_ni, .start_i, .op_i, .accept_o(accept), .busy_o(busy)
  );

  fws_status i_status (
    .clk_i, .rst_ni, .accept_i(accept), .op_i, .wdata_i,
    .rd_busy_i(rd_i & busy), .status_o(status)
  );

  fws_rdmux #(
    .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) i_rdmux (
    .addr_i(rd_addr_i), .id_mode_i, .array_data_i, .idle_o(idle_data)
  );

  // status has priority over id mode while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= busy ? status : idle_data;
  end

  assign busy_o  = busy;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fws_chk.sv
module fws_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic [7:0] wdata_i,
  input logic       rd_i,
  input logic       busy_o,
  input logic [7:0] rdata_o
);
  logic acc;
  logic last_prog, last_w7, first_pend, prev_rd;

  assign acc = start_i && !busy_o && (op_i != 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_prog  <= 1'b0;
      last_w7    <= 1'b0;
      first_pend <= 1'b0;
      prev_rd    <= 1'b0;
    end else begin
      prev_rd <= rd_i && busy_o;
      if (acc) begin
        last_prog  <= (op_i == 2'b00);
        last_w7    <= wdata_i[7];
        first_pend <= 1'b1;
      end else if (rd_i && busy_o) begin
        first_pend <= 1'b0;
      end
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);
  // R2
  no_spurious_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !acc) |=> !busy_o);
  // R4
  prog_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && last_prog) |=> (rdata_o[7] == ~last_w7) && (rdata_o[5:0] == 6'b0));
  // R5
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && !last_prog) |=> (rdata_o[7] == 1'b0) && (rdata_o[5:0] == 6'b0));
  // R6
  first_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && first_pend) |=> rdata_o[6]);
  // R6
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && prev_rd && !first_pend) |=> (rdata_o[6] != $past(rdata_o[6])));
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind flash_wstat_gen fws_chk i_fws_chk (.*);

// File: tb/test_flash_wstat_gen.sv
module test_flash_wstat_gen;
  localparam int AW = 8;
  localparam int NP = 5;
  localparam int NS = 8;
  localparam int NC = 13;
  localparam logic [7:0] MFR = 8'hBF;
  localparam logic [7:0] DEV = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] wd = 8'h00;
  logic rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic idm = 1'b0;
  logic [7:0] arr_data;
  logic busy;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction
  assign arr_data = arr(addr);

  flash_wstat_gen #(
    .ADDR_W(AW), .PROG_CYC(NP), .SECT_CYC(NS), .CHIP_CYC(NC),
    .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) i_flash_wstat_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wdata_i(wd),
    .rd_i(rd), .rd_addr_i(addr), .id_mode_i(idm), .array_data_i(arr_data),
    .busy_o(busy), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_start(input logic [1:0] o, input logic [7:0] w);
    start = 1'b1; op = o; wd = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic int dur(input int o);
    return (o == 0) ? NP : (o == 1) ? NS : NC;
  endfunction

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h80;
      2: return 8'h7F;
      3: return 8'hFF;
      4: return 8'h5A;
      default: return 8'hA5;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold;
    int cnt;
    logic t;
    logic [7:0] e;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && rdata == 8'h00, "R1 after release", rdata, 0);

    // R2 durations
    for (int o = 0; o < 3; o++) begin
      do_start(o[1:0], 8'h33);
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
      chk(cnt == dur(o), "R2 duration", cnt, dur(o));
    end
    do_start(2'b11, 8'h00);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R2 op none", cnt, 0);

    // R4 R5 R6 R7 sweep
    for (int o = 0; o < 3; o++) begin
      for (int p = 0; p < 6; p++) begin
        do_start(o[1:0], pat(p));
        t = 1'b1;
        for (int k = 0; k < dur(o); k++) begin
          do_read(8'(k));
          e = {(o == 0) ? ~pat(p)[7] : 1'b0, t, 6'b0};
          chk(rdata == e, (o == 0) ? "R4 R6 program status" : "R5 R6 erase status",
              rdata, e);
          t = ~t;
        end
        chk(busy == 1'b0, "R2 end of window", busy, 0);
        do_read(8'(8'h40 + p));
        chk(rdata == arr(8'(8'h40 + p)), "R7 idle read", rdata, arr(8'(8'h40 + p)));
      end
    end

    // R3 start while busy ignored
    do_start(2'b00, 8'h00);
    do_start(2'b10, 8'h80);
    do_read(8'h10);
    chk(rdata == 8'hC0, "R3 R6 ignored start", rdata, 8'hC0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == NP - 2, "R3 no extension", cnt, NP - 2);

    // R8 id mode
    idm = 1'b1;
    do_read(8'h00);
    chk(rdata == MFR, "R8 mfr code", rdata, MFR);
    do_read(8'h01);
    chk(rdata == DEV, "R8 dev code", rdata, DEV);
    do_read(8'h02);
    chk(rdata == arr(8'h02), "R8 outside window", rdata, arr(8'h02));
    do_start(2'b01, 8'h00);
    do_read(8'h00);
    chk(rdata == 8'h40, "R8 status over id", rdata, 8'h40);
    while (busy) @(negedge clk);
    idm = 1'b0;
    do_read(8'h01);
    chk(rdata == arr(8'h01), "R7 id off", rdata, arr(8'h01));

    // R9 hold
    hold = rdata;
    addr = 8'h77;
    repeat (3) @(negedge clk);
    chk(rdata == hold, "R9 hold", rdata, hold);
    do_start(2'b00, 8'h12);
    repeat (2) @(negedge clk);
    chk(rdata == hold, "R9 hold while busy", rdata, hold);
    while (busy) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule